// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block keeps a short queue of cache-line prefetch entries next to a first-level data cache. Prefetched lines stay in the queue and are never written into the cache arrays. Every cache lookup also compares its line address against the oldest queue entry in the same cycle. If that entry matches and its data has arrived, the block supplies the line straight to the cache. It then retires the entry and appends the line that follows the youngest queued address, so the stream always runs `DEPTH` lines ahead.

A cache miss that does not match the oldest entry discards the whole stream. It then restarts the queue at the line after the missed one and covers `DEPTH` consecutive lines. Line requests leave in queue order through a valid/ready request port. Responses come back in request order. Responses that belong to a discarded stream are counted and thrown away, so they cannot land in a newer entry. The number of line requests in flight, stale or live, is capped.

Top module: `pfb_stream_buf`

## Requirements
- R1: After reset, `hit_o`, `pend_hit_o` and `mem_req_valid_o` are all low until a lookup reports a miss.
- R2: A lookup with `l1_miss_i` high whose line does not match the oldest entry restarts the stream. The next `DEPTH` requests issued are for miss line + 64, + 128, and so on up to + 64*`DEPTH` bytes, in that order, with the 6 low address bits zero.
- R3: In the same cycle as `lookup_valid_i`, `hit_o` is high exactly when the lookup line equals the oldest entry's line and that entry's data has arrived.
- R4: When the oldest entry matches but its data has not arrived, `pend_hit_o` is high and `hit_o` is low. The queue keeps its order and contents, and no extra request for that line is issued.
- R5: On a hit the oldest entry is retired. A request is then queued for the line 64 bytes after the youngest queued line.
- R6: In a hit cycle, `line_data_o` carries the response data that memory returned for that line.
- R7: Responses to requests issued before a restart are discarded. They never appear on `line_data_o` for a line of the new stream.
- R8: `mem_req_valid_o` is high only while some queued line is still unrequested and fewer than `MAX_OUT` requests are in flight. Discarded requests count toward that number until their responses return.
- R9: Only the oldest entry is probed. A miss whose line sits deeper in the queue restarts the stream as in R2 and gives no hit.
- R10: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address hold in the next cycle, unless that cycle's lookup restarts the stream.
- R11: A lookup with `l1_miss_i` low that does not match the oldest entry changes nothing. The oldest entry still hits on a following lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | A cache lookup takes place this cycle |
| lookup_addr_i | input | ADDR_W | Byte address of the lookup |
| l1_miss_i | input | 1 | The cache missed on this lookup |
| hit_o | output | 1 | Oldest entry matches and its line is ready |
| pend_hit_o | output | 1 | Oldest entry matches, its line is still in flight |
| line_data_o | output | DATA_W | Line supplied to the cache in a hit cycle |
| mem_req_valid_o | output | 1 | Line request to the next level is valid |
| mem_req_ready_i | input | 1 | Next level accepts the request |
| mem_req_addr_o | output | ADDR_W | Line-aligned address of the request |
| mem_resp_valid_i | input | 1 | A line response arrives, in request order |
| mem_resp_data_i | input | DATA_W | Response line data |

## Verification
The bench builds the block with a 32-bit line data word in place of the full 512-bit line. This keeps the data checks light and still tells responses apart by address. It keeps a four-entry queue and lowers `MAX_OUT` to 6, so two or three quick restarts against a 30-cycle memory fill the in-flight budget and make the cap observable. Memory latency of 3 to 30 cycles and ready throttling bring out pending hits, stalled requests and stale responses that cross a restart.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef struct packed {
    logic vld;
    logic req;
    logic rdy;
  } ent_flags_t;

  localparam ent_flags_t ENT_FRESH = '{vld: 1'b1, req: 1'b0, rdy: 1'b0};
endpackage

// File: rtl/pfb_age_pick.sv
// first set bit of mask_i in age order starting at head_i
module pfb_age_pick #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic [PTR_W-1:0] head_i,
  input  logic [DEPTH-1:0] mask_i,
  output logic             found_o,
  output logic [PTR_W-1:0] slot_o
);
  logic [DEPTH-1:0] aged;
  logic [PTR_W-1:0] off;

  for (genvar k = 0; k < DEPTH; k++) begin : g_rot
    assign aged[k] = mask_i[PTR_W'(head_i + PTR_W'(k))];
  end

  always_comb begin
    found_o = 1'b0;
    off     = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (aged[k]) begin
        found_o = 1'b1;
        off     = PTR_W'(k);
      end
    end
  end

  assign slot_o = head_i + off;
endmodule

// File: rtl/pfb_stale_ctr.sv
// in-flight requests orphaned by restarts
module pfb_stale_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             resp_valid_i,
  input  logic             req_fire_i,
  input  logic [CNT_W-1:0] live_i,
  output logic [CNT_W-1:0] stale_o,
  output logic             drop_o,
  output logic             resp_live_o
);
  logic [CNT_W-1:0] nxt;

  assign drop_o      = resp_valid_i & (stale_o != '0);
  assign resp_live_o = resp_valid_i & (stale_o == '0) & (live_i != '0);

  always_comb begin
    nxt = stale_o - CNT_W'(drop_o);
    if (flush_i) nxt = nxt + live_i - CNT_W'(resp_live_o) + CNT_W'(req_fire_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stale_o <= '0;
    else         stale_o <= nxt;
  end
endmodule

// File: rtl/pfb_stream_buf.sv
module pfb_stream_buf
  import pfb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 512,
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              l1_miss_i,
  output logic              hit_o,
  output logic              pend_hit_o,
  output logic [DATA_W-1:0] line_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_resp_valid_i,
  input  logic [DATA_W-1:0] mem_resp_data_i
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(MAX_OUT + DEPTH + 1);

  logic [LA_W-1:0]   line_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  ent_flags_t        flg_q  [DEPTH];
  logic [PTR_W-1:0]  head_q;
  logic [LA_W-1:0]   tail_line_q;

  logic [LA_W-1:0]  look_line;
  logic             unused_off;
  logic             head_match, flush, pop;
  logic [DEPTH-1:0] need_req, wait_rsp;
  logic [CNT_W-1:0] live_out, stale_q;
  logic             req_found, rsp_found, req_fire, drop, resp_live;
  logic [PTR_W-1:0] req_slot, rsp_slot;

  assign look_line  = lookup_addr_i[ADDR_W-1:OFF_W];
  assign unused_off = ^lookup_addr_i[OFF_W-1:0];

  // probe oldest entry only, same cycle as the cache
  assign head_match = lookup_valid_i & flg_q[head_q].vld & (line_q[head_q] == look_line);
  assign hit_o       = head_match & flg_q[head_q].rdy;
  assign pend_hit_o  = head_match & ~flg_q[head_q].rdy;
  assign line_data_o = data_q[head_q];
  assign flush       = lookup_valid_i & l1_miss_i & ~head_match;
  assign pop         = hit_o;

  always_comb begin
    live_out = '0;
    for (int s = 0; s < DEPTH; s++) begin
      need_req[s] = flg_q[s].vld & ~flg_q[s].req;
      wait_rsp[s] = flg_q[s].vld & flg_q[s].req & ~flg_q[s].rdy;
      live_out    = live_out + CNT_W'(wait_rsp[s]);
    end
  end

  pfb_age_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_req_pick (
    .head_i (head_q),
    .mask_i (need_req),
    .found_o(req_found),
    .slot_o (req_slot)
  );

  pfb_age_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rsp_pick (
    .head_i (head_q),
    .mask_i (wait_rsp),
    .found_o(rsp_found),
    .slot_o (rsp_slot)
  );

  pfb_stale_ctr #(.CNT_W(CNT_W)) u_stale (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .resp_valid_i(mem_resp_valid_i),
    .req_fire_i  (req_fire),
    .live_i      (live_out),
    .stale_o     (stale_q),
    .drop_o      (drop),
    .resp_live_o (resp_live)
  );

  assign mem_req_valid_o = req_found & ((stale_q + live_out) < CNT_W'(MAX_OUT));
  assign mem_req_addr_o  = {line_q[req_slot], {OFF_W{1'b0}}};
  assign req_fire        = mem_req_valid_o & mem_req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) begin
        line_q[s] <= '0;
        data_q[s] <= '0;
        flg_q[s]  <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < DEPTH; s++) begin
        line_q[s] <= look_line + LA_W'(s + 1);
        flg_q[s]  <= ENT_FRESH;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (resp_live && rsp_found && rsp_slot == PTR_W'(s)) begin
          data_q[s]     <= mem_resp_data_i;
          flg_q[s].rdy  <= 1'b1;
        end
        if (req_fire && req_slot == PTR_W'(s)) flg_q[s].req <= 1'b1;
        // retired slot becomes the new youngest line
        if (pop && head_q == PTR_W'(s)) begin
          line_q[s] <= tail_line_q + LA_W'(1);
          flg_q[s]  <= ENT_FRESH;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q      <= '0;
      tail_line_q <= '0;
    end else if (flush) begin
      head_q      <= '0;
      tail_line_q <= look_line + LA_W'(DEPTH);
    end else if (pop) begin
      head_q      <= head_q + PTR_W'(1);
      tail_line_q <= tail_line_q + LA_W'(1);
    end
  end
endmodule

// File: rtl/pfb_stream_buf_chk.sv
module pfb_stream_buf_chk #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  parameter int LA_W    = 26,
  parameter int PTR_W   = 2,
  parameter int CNT_W   = 4,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_valid_i,
  input logic              l1_miss_i,
  input logic [ADDR_W-1:0] lookup_addr_i,
  input logic              hit_o,
  input logic              pend_hit_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              mem_resp_valid_i,
  input logic [CNT_W-1:0]  stale_i,
  input logic [CNT_W-1:0]  live_i,
  input logic [PTR_W-1:0]  head_i,
  input logic [LA_W-1:0]   tail_i
);
  logic            restart;
  logic [LA_W-1:0] la_line;

  assign restart = lookup_valid_i & l1_miss_i & ~hit_o & ~pend_hit_o;
  assign la_line = lookup_addr_i[ADDR_W-1:OFF_W];

  a_r3_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && pend_hit_o));

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> tail_i == $past(la_line) + LA_W'(DEPTH));

  a_r4_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_hit_o |=> $stable(head_i) && $stable(tail_i));

  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> head_i == $past(head_i) + PTR_W'(1) && tail_i == $past(tail_i) + LA_W'(1));

  a_r7_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_resp_valid_i && stale_i != '0 && !restart |=> stale_i == $past(stale_i) - CNT_W'(1));

  a_r8_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(stale_i) + 32'(live_i)) <= MAX_OUT);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i && !restart |=> mem_req_valid_o && $stable(mem_req_addr_o));
endmodule

bind pfb_stream_buf pfb_stream_buf_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LA_W(LA_W), .PTR_W(PTR_W),
  .CNT_W(CNT_W), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lookup_valid_i  (lookup_valid_i),
  .l1_miss_i       (l1_miss_i),
  .lookup_addr_i   (lookup_addr_i),
  .hit_o           (hit_o),
  .pend_hit_o      (pend_hit_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_resp_valid_i(mem_resp_valid_i),
  .stale_i         (stale_q),
  .live_i          (live_out),
  .head_i          (head_q),
  .tail_i          (tail_line_q)
);

// File: tb/pfb_stream_buf_bench.sv
`timescale 1ns/1ps
module pfb_stream_buf_bench;
  localparam int AW = 32, DW = 32, DEP = 4, MAXO = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          lookup_valid = 1'b0, l1_miss = 1'b0, mem_ready = 1'b0, resp_v = 1'b0;
  logic [AW-1:0] lookup_addr = '0;
  logic [DW-1:0] resp_d = '0;
  logic          hit_o, pend_hit_o, mem_req_valid_o;
  logic [DW-1:0] line_data_o;
  logic [AW-1:0] mem_req_addr_o;

  pfb_stream_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP), .LINE_BYTES(64), .MAX_OUT(MAXO))
  u_pfb_stream_buf (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_valid_i(lookup_valid), .lookup_addr_i(lookup_addr),
    .l1_miss_i(l1_miss), .hit_o(hit_o), .pend_hit_o(pend_hit_o), .line_data_o(line_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_ready), .mem_req_addr_o(mem_req_addr_o),
    .mem_resp_valid_i(resp_v), .mem_resp_data_i(resp_d)
  );

  typedef struct {
    logic [31:0] line;
    bit          req;
    bit          rdy;
  } ment_t;

  ment_t       q[$];
  logic [31:0] mq_a[$], fire_log[$];
  int          mq_t[$];
  int          stale = 0, cyc = 0, lat = 3, rdy_mode = 0, capped = 0;
  logic [31:0] tail = 0;
  int          total = 0, bad = 0;
  bit          done = 0, last_hit = 0;
  logic [31:0] last_data = 0;
  bit          p_v = 0, p_rdy = 0, p_fl = 0;
  logic [31:0] p_addr = 0;

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit lv, input logic [31:0] la, input bit miss);
    int ri, wi, live;
    bit match, e_hit, e_pend, e_rv, fire, rlive, fl;
    logic [31:0] e_addr;
    @(negedge clk);
    lookup_valid = lv; lookup_addr = la; l1_miss = miss;
    mem_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
    if (mq_a.size() > 0 && mq_t[0] <= cyc) begin
      resp_v = 1'b1; resp_d = mem_f(mq_a[0]);
      void'(mq_a.pop_front()); void'(mq_t.pop_front());
    end else resp_v = 1'b0;
    #1;
    match  = lv && q.size() > 0 && q[0].line == (la >> 6);
    e_hit  = match && q[0].rdy;
    e_pend = match && !q[0].rdy;
    ri = -1; wi = -1; live = 0;
    foreach (q[i]) begin
      if (!q[i].req && ri < 0) ri = i;
      if (q[i].req && !q[i].rdy) begin live++; if (wi < 0) wi = i; end
    end
    e_rv   = ri >= 0 && (stale + live) < MAXO;
    e_addr = e_rv ? (q[ri].line << 6) : 32'h0;
    chk(hit_o === e_hit, "R3 hit", 64'(hit_o), 64'(e_hit));
    chk(pend_hit_o === e_pend, "R4 pending", 64'(pend_hit_o), 64'(e_pend));
    if (e_hit) chk(line_data_o === mem_f(la & ~32'h3F), "R6 data", 64'(line_data_o), 64'(mem_f(la & ~32'h3F)));
    chk(mem_req_valid_o === e_rv, "R8 req_valid", 64'(mem_req_valid_o), 64'(e_rv));
    if (e_rv) chk(mem_req_addr_o === e_addr, "R2 req_addr", 64'(mem_req_addr_o), 64'(e_addr));
    if (p_v && !p_rdy && !p_fl)
      chk(mem_req_valid_o === 1'b1 && mem_req_addr_o === p_addr, "R10 hold", 64'(mem_req_addr_o), 64'(p_addr));
    if (ri >= 0 && !e_rv) capped++;
    fire = e_rv && mem_ready;
    fl   = lv && miss && !match;
    if (fire) begin mq_a.push_back(e_addr); mq_t.push_back(cyc + lat); fire_log.push_back(e_addr); end
    rlive = 0;
    if (resp_v) begin
      if (stale > 0) stale--;
      else if (wi >= 0) begin q[wi].rdy = 1; rlive = 1; end
    end
    if (fl) begin
      stale = stale + live - int'(rlive) + int'(fire);
      q.delete();
      for (int k = 0; k < DEP; k++) q.push_back('{line: (la >> 6) + k + 1, req: 0, rdy: 0});
      tail = (la >> 6) + DEP;
    end else begin
      if (fire) q[ri].req = 1;
      if (e_hit) begin
        void'(q.pop_front());
        tail = tail + 1;
        q.push_back('{line: tail, req: 0, rdy: 0});
      end
    end
    p_v = e_rv; p_rdy = mem_ready; p_fl = fl; p_addr = e_addr;
    last_hit = e_hit;
    if (e_hit) last_data = line_data_o;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0);
  endtask

  task automatic fetch(input logic [31:0] a);
    for (int n = 0; n < 80; n++) begin
      step(1'b1, a, 1'b1);
      if (last_hit) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    idle(1);
    chk(!hit_o && !pend_hit_o && !mem_req_valid_o, "R1 reset", {hit_o, pend_hit_o, mem_req_valid_o}, 0);
    idle(2);

    // R2 restart after a miss
    fire_log.delete();
    step(1'b1, 32'h1000, 1'b1);
    idle(12);
    chk(fire_log.size() == 4, "R2 count", fire_log.size(), 4);
    for (int k = 0; k < 4 && k < fire_log.size(); k++)
      chk(fire_log[k] == 32'h1040 + 64 * k, "R2 order", fire_log[k], 32'h1040 + 64 * k);

    // R5 hit refills after youngest
    fire_log.delete();
    fetch(32'h1040);
    chk(last_hit && last_data == mem_f(32'h1040), "R5 hit", last_data, mem_f(32'h1040));
    idle(3);
    chk(fire_log.size() > 0 && fire_log[0] == 32'h1140, "R5 next line",
        fire_log.size() > 0 ? fire_log[0] : 0, 32'h1140);

    // R11 non-miss lookup with no match is ignored
    fire_log.delete();
    step(1'b1, 32'h5000, 1'b0);
    idle(2);
    chk(fire_log.size() == 0, "R11 no request", fire_log.size(), 0);
    step(1'b1, 32'h1080, 1'b1);
    chk(last_hit, "R11 head kept", 64'(last_hit), 1);

    // R9 deeper line is not probed
    idle(4);
    fire_log.delete();
    step(1'b1, 32'h1100, 1'b1);
    chk(!last_hit, "R9 no hit", 64'(last_hit), 0);
    idle(12);
    chk(fire_log.size() == 4 && fire_log[0] == 32'h1140 && fire_log[3] == 32'h1200, "R9 restart",
        fire_log.size() > 0 ? fire_log[0] : 0, 32'h1140);

    // R4 pending hits under throttled memory
    rdy_mode = 1; lat = 5;
    step(1'b1, 32'h40000, 1'b1);
    for (int i = 1; i <= 12; i++) begin
      fetch(32'h40000 + 64 * i);
      chk(last_hit, "R4 stream", 64'(last_hit), 1);
    end
    rdy_mode = 0; idle(20);

    // R7 stale responses across a restart
    lat = 8;
    step(1'b1, 32'h8000, 1'b1);
    idle(3);
    step(1'b1, 32'h20000, 1'b1);
    fetch(32'h20040);
    chk(last_hit && last_data == mem_f(32'h20040), "R7 fresh data", last_data, mem_f(32'h20040));
    fetch(32'h20080);
    chk(last_hit && last_data == mem_f(32'h20080), "R7 fresh data", last_data, mem_f(32'h20080));
    idle(20);

    // R8 in-flight cap
    lat = 30; capped = 0;
    step(1'b1, 32'hA000, 1'b1);
    idle(2);
    step(1'b1, 32'hB000, 1'b1);
    idle(2);
    step(1'b1, 32'hC000, 1'b1);
    idle(60);
    chk(capped > 0, "R8 cap reached", capped, 1);
    fetch(32'hC040);
    chk(last_hit && last_data == mem_f(32'hC040), "R8 recover", last_data, mem_f(32'hC040));
    idle(40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule